// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block holds the 32-bit floating-point status and control word of a core and updates it once for each completing instruction. With each completion the pipeline presents an instruction class, the exception bits that the datapath newly raised, the fraction-rounded and fraction-inexact flags, and a five-bit result class code. The unit merges the exceptions into sticky bits and derives the exception summary, the invalid-operation summary and the enabled-exception flag. It also flags results whose register write must be dropped.

Each class updates the word in its own way. Move-type operations leave the word alone. Round-to-integer operations can never raise inexact. Special-case arithmetic and round-to-integer clear the rounding flags. Conversions to integer zero the result class. Status-register instructions can set or clear single bits, copy a 4-bit field to a condition-register field, or read the word. One reserved bit always reads as zero. The invalid summary and the enabled-exception flag are derived from other bits and cannot be written.

Top module: `fpsu_top`

## Requirements
- R1: After reset the status word reads 0, and suppressWrite and crWe are 0.
- R2: Bit layout, LSB-0: RN 1:0, XE 3, ZE 4, UE 5, OE 6, VE 7, invalid causes at 8 (integer convert), 9 (square root), 10 (software) and 19 to 24 (compare, Inf*0, 0/0, Inf/Inf, Inf-Inf, SNaN), class field 16:12, FI 17, FR 18, XX 25, ZX 26, UX 27, OX 28, VX 29, FEX 30, FX 31. Arithmetic (class 0) ORs newExc into the sticky bits and loads FR, FI and the class field from its inputs.
- R3: FX is set whenever an individual exception bit (an invalid cause, OX, UX, ZX or XX) goes from 0 to 1. A new cause raised while VX is already 1 still sets FX, and raising a cause that is already set does not.
- R4: Set-bit (class 6) and clear-bit (class 7) act on bit bitIdx. A set-bit that takes an individual exception bit from 0 to 1 also sets FX. Writes to bits 11, 29 and 30 have no effect.
- R5: VX is the OR of the nine invalid causes. FEX is the OR of VX, OX, UX, ZX and XX, each ANDed with its enable bit. Both follow changes of their inputs.
- R6: Move-type (class 2) and cycles with instDone low leave the whole status word unchanged.
- R7: Round-to-integer (class 3) clears FR and FI and never sets XX, even if newExc carries it.
- R8: Special-case arithmetic (class 1) accumulates exceptions but clears FR and FI whatever its inputs are.
- R9: Convert-from-integer (class 5) replaces FR and FI with the new values, so flags set by an earlier instruction do not persist.
- R10: Convert-to-integer (class 4) sets the class field to 0.
- R11: One cycle after a completing computational class (0, 1, 3, 4, 5) raises an invalid cause while VE is 1, or raises ZX while ZE is 1, suppressWrite is 1. Otherwise it is 0.
- R12: Move-field-to-CR (class 8) loads crField with word bits [31-4k : 28-4k] for k = fieldIdx, with bit 11 forced to 0, and pulses crWe.
- R13: Plain read (class 9) with recordBit set loads crField with {FX, FEX, VX, OX} and pulses crWe. The read variant (class 10) ignores recordBit and never pulses crWe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instDone | input | 1 | An instruction completes this cycle |
| opClass | input | 4 | Class code of the completing instruction |
| newExc | input | 32 | Newly raised exception bits, in status-word positions |
| frIn | input | 1 | Fraction-rounded flag from the datapath |
| fiIn | input | 1 | Fraction-inexact flag from the datapath |
| resultClass | input | 5 | Result class code |
| bitIdx | input | 5 | Target bit for set-bit and clear-bit |
| fieldIdx | input | 3 | Field index for move-field-to-CR |
| recordBit | input | 1 | Record request of read instructions |
| statusReg | output | 32 | Current status and control word |
| crField | output | 4 | Field delivered to the condition register |
| crWe | output | 1 | crField is valid this cycle |
| suppressWrite | output | 1 | Drop the destination write of the completed instruction |

## Verification
Some rules are checked by assertions on every cycle. A new invalid cause always leaves FX set. Round-to-integer leaves FR and FI clear and XX as it was. Convert-to-integer zeroes the class field. An enabled invalid cause always raises suppressWrite. Move-type completions keep the word stable. Other behaviour can only be shown by the bench's ordered scenarios. These are FX rising again when VX is already set, FX staying clear when a cause is raised again, derived bits refusing writes, FEX following enable changes, and the reserved bit staying out of copied fields.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

  localparam int WORD_W   = 32;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int NIB_W    = 4;
  localparam int FIELDS   = WORD_W / NIB_W;
  localparam int FLD_W    = $clog2(FIELDS);
  localparam int CLASS_W  = 5;
  localparam int CLASS_LO = 12;

  localparam int B_XE   = 3;
  localparam int B_ZE   = 4;
  localparam int B_UE   = 5;
  localparam int B_OE   = 6;
  localparam int B_VE   = 7;
  localparam int B_RSVD = 11;
  localparam int B_FI   = 17;
  localparam int B_FR   = 18;
  localparam int B_XX   = 25;
  localparam int B_ZX   = 26;
  localparam int B_UX   = 27;
  localparam int B_OX   = 28;
  localparam int B_VX   = 29;
  localparam int B_FEX  = 30;
  localparam int B_FX   = 31;

  // invalid-operation causes: bits 8,9,10 and 19..24
  localparam logic [WORD_W-1:0] CAUSE_MASK = 32'h01F8_0700;
  localparam logic [WORD_W-1:0] EXC_MASK   = CAUSE_MASK
      | (32'h1 << B_OX) | (32'h1 << B_UX) | (32'h1 << B_ZX) | (32'h1 << B_XX);
  // bits held in storage (derived and reserved bits excluded)
  localparam logic [WORD_W-1:0] STORE_MASK =
      ~((32'h1 << B_RSVD) | (32'h1 << B_VX) | (32'h1 << B_FEX));

  typedef enum logic [3:0] {
    CLS_ARITH   = 4'd0,
    CLS_SPECIAL = 4'd1,
    CLS_MOVE    = 4'd2,
    CLS_RINT    = 4'd3,
    CLS_TOINT   = 4'd4,
    CLS_FROMINT = 4'd5,
    CLS_SETBIT  = 4'd6,
    CLS_CLRBIT  = 4'd7,
    CLS_TOCR    = 4'd8,
    CLS_READ    = 4'd9,
    CLS_READALT = 4'd10
  } opClass_e;

  typedef enum logic [1:0] {
    SEL_KEEP = 2'd0,
    SEL_NEW  = 2'd1,
    SEL_ZERO = 2'd2
  } fldSel_e;

  typedef struct packed {
    logic    accumExc;
    logic    dropInexact;
    fldSel_e frfiSel;
    fldSel_e fprfSel;
    logic    setBit;
    logic    clrBit;
    logic    cpyField;
    logic    cpySummary;
    logic    chkSuppress;
  } strobe_t;

endpackage

// File: rtl/fpsu_ctrl.sv
module fpsu_ctrl
  import fpsu_pkg::*;
(
  input  logic       instDone,
  input  logic [3:0] opClass,
  input  logic       recordBit,
  output strobe_t    stb
);

  always_comb begin
    stb = '0;
    if (instDone) begin
      case (opClass)
        CLS_ARITH: begin
          stb.accumExc    = 1'b1;
          stb.frfiSel     = SEL_NEW;
          stb.fprfSel     = SEL_NEW;
          stb.chkSuppress = 1'b1;
        end
        CLS_SPECIAL: begin
          stb.accumExc    = 1'b1;
          stb.frfiSel     = SEL_ZERO;
          stb.fprfSel     = SEL_NEW;
          stb.chkSuppress = 1'b1;
        end
        CLS_RINT: begin
          stb.accumExc    = 1'b1;
          stb.dropInexact = 1'b1;
          stb.frfiSel     = SEL_ZERO;
          stb.fprfSel     = SEL_NEW;
          stb.chkSuppress = 1'b1;
        end
        CLS_TOINT: begin
          stb.accumExc    = 1'b1;
          stb.frfiSel     = SEL_NEW;
          stb.fprfSel     = SEL_ZERO;
          stb.chkSuppress = 1'b1;
        end
        CLS_FROMINT: begin
          stb.accumExc    = 1'b1;
          stb.frfiSel     = SEL_NEW;
          stb.fprfSel     = SEL_NEW;
          stb.chkSuppress = 1'b1;
        end
        CLS_SETBIT:  stb.setBit     = 1'b1;
        CLS_CLRBIT:  stb.clrBit     = 1'b1;
        CLS_TOCR:    stb.cpyField   = 1'b1;
        CLS_READ:    stb.cpySummary = recordBit;
        default: ;  // move-type and read variant: no update
      endcase
    end
  end

endmodule

// File: rtl/fpsu_datapath.sv
module fpsu_datapath
  import fpsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  logic [WORD_W-1:0]  newExc,
  input  logic               frIn,
  input  logic               fiIn,
  input  logic [CLASS_W-1:0] resultClass,
  input  logic [IDX_W-1:0]   bitIdx,
  input  logic [FLD_W-1:0]   fieldIdx,
  output logic [WORD_W-1:0]  statusOut,
  output logic [NIB_W-1:0]   crField,
  output logic               crWe,
  output logic               suppressWrite
);

  logic [WORD_W-1:0] stateQ;
  logic [WORD_W-1:0] stateNext;
  logic [WORD_W-1:0] raised;
  logic [WORD_W-1:0] fieldWord;
  logic [IDX_W-1:0]  fieldShift;
  logic [NIB_W-1:0]  fieldVal;
  logic [NIB_W-1:0]  summaryVal;
  logic              vxSum;
  logic              fexSum;
  logic              fxRise;
  logic              supNext;

  // derived summaries
  always_comb begin
    vxSum  = |(stateQ & CAUSE_MASK);
    fexSum = |({vxSum, stateQ[B_OX], stateQ[B_UX], stateQ[B_ZX], stateQ[B_XX]} &
               {stateQ[B_VE], stateQ[B_OE], stateQ[B_UE], stateQ[B_ZE], stateQ[B_XE]});
    statusOut         = stateQ & STORE_MASK;
    statusOut[B_VX]   = vxSum;
    statusOut[B_FEX]  = fexSum;
  end

  // next-state merge
  always_comb begin
    stateNext = stateQ;
    raised    = '0;
    if (stb.accumExc) begin
      raised = newExc & EXC_MASK;
      if (stb.dropInexact) raised[B_XX] = 1'b0;
      stateNext = stateNext | raised;
    end
    case (stb.frfiSel)
      SEL_NEW:  begin stateNext[B_FR] = frIn; stateNext[B_FI] = fiIn; end
      SEL_ZERO: begin stateNext[B_FR] = 1'b0; stateNext[B_FI] = 1'b0; end
      default: ;
    endcase
    case (stb.fprfSel)
      SEL_NEW:  stateNext[CLASS_LO +: CLASS_W] = resultClass;
      SEL_ZERO: stateNext[CLASS_LO +: CLASS_W] = '0;
      default: ;
    endcase
    if (stb.setBit) stateNext[bitIdx] = 1'b1;
    if (stb.clrBit) stateNext[bitIdx] = 1'b0;
    fxRise = |(stateNext & ~stateQ & EXC_MASK);
    if (fxRise) stateNext[B_FX] = 1'b1;
    stateNext = stateNext & STORE_MASK;
  end

  // field extraction for the condition register
  always_comb begin
    fieldShift = IDX_W'((FIELDS - 1 - int'(fieldIdx)) * NIB_W);
    fieldWord  = (statusOut & ~(32'h1 << B_RSVD)) >> fieldShift;
    fieldVal   = fieldWord[NIB_W-1:0];
    summaryVal = {statusOut[B_FX], statusOut[B_FEX], statusOut[B_VX], statusOut[B_OX]};
    supNext    = stb.chkSuppress &
                 (((|(newExc & CAUSE_MASK)) & stateQ[B_VE]) |
                  (newExc[B_ZX] & stateQ[B_ZE]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ        <= '0;
      crField       <= '0;
      crWe          <= 1'b0;
      suppressWrite <= 1'b0;
    end else begin
      stateQ        <= stateNext;
      crWe          <= stb.cpyField | stb.cpySummary;
      suppressWrite <= supNext;
      if (stb.cpyField)        crField <= fieldVal;
      else if (stb.cpySummary) crField <= summaryVal;
    end
  end

  // R3
  fx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.accumExc && |(newExc & CAUSE_MASK & ~stateQ)) |=> statusOut[B_FX]);

  // R7
  rint_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.dropInexact |=> (!statusOut[B_FR] && !statusOut[B_FI] &&
                         statusOut[B_XX] == $past(statusOut[B_XX])));

  // R10
  toint_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.fprfSel == SEL_ZERO) |=> (statusOut[CLASS_LO +: CLASS_W] == '0));

  // R11
  suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.chkSuppress && stateQ[B_VE] && |(newExc & CAUSE_MASK)) |=> suppressWrite);

endmodule

// File: rtl/fpsu_top.sv
module fpsu_top
  import fpsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instDone,
  input  logic [3:0]  opClass,
  input  logic [31:0] newExc,
  input  logic        frIn,
  input  logic        fiIn,
  input  logic [4:0]  resultClass,
  input  logic [4:0]  bitIdx,
  input  logic [2:0]  fieldIdx,
  input  logic        recordBit,
  output logic [31:0] statusReg,
  output logic [3:0]  crField,
  output logic        crWe,
  output logic        suppressWrite
);

  strobe_t stb;

  fpsu_ctrl u_ctrl (
    .instDone  (instDone),
    .opClass   (opClass),
    .recordBit (recordBit),
    .stb       (stb)
  );

  fpsu_datapath u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .stb           (stb),
    .newExc        (newExc),
    .frIn          (frIn),
    .fiIn          (fiIn),
    .resultClass   (resultClass),
    .bitIdx        (bitIdx),
    .fieldIdx      (fieldIdx),
    .statusOut     (statusReg),
    .crField       (crField),
    .crWe          (crWe),
    .suppressWrite (suppressWrite)
  );

  // R6
  move_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instDone && opClass == CLS_MOVE) |=> $stable(statusReg));

endmodule

// File: tb/fpsu_top_tb.sv
`timescale 1ns/1ps
module fpsu_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instDone = 1'b0;
  logic [3:0]  opClass = '0;
  logic [31:0] newExc = '0;
  logic        frIn = 1'b0;
  logic        fiIn = 1'b0;
  logic [4:0]  resultClass = '0;
  logic [4:0]  bitIdx = '0;
  logic [2:0]  fieldIdx = '0;
  logic        recordBit = 1'b0;
  logic [31:0] statusReg;
  logic [3:0]  crField;
  logic        crWe;
  logic        suppressWrite;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpsu_top u_dut (
    .clk(clk), .rst_n(rst_n), .instDone(instDone), .opClass(opClass),
    .newExc(newExc), .frIn(frIn), .fiIn(fiIn), .resultClass(resultClass),
    .bitIdx(bitIdx), .fieldIdx(fieldIdx), .recordBit(recordBit),
    .statusReg(statusReg), .crField(crField), .crWe(crWe),
    .suppressWrite(suppressWrite)
  );

  typedef struct packed {
    logic [3:0]  cls;
    logic [31:0] exc;
    logic        fr;
    logic        fi;
    logic [4:0]  rc;
    logic [4:0]  idx;
    logic [2:0]  fld;
    logic        rec;
    logic [31:0] expStat;
    logic        expSup;
    logic        expCrWe;
    logic [3:0]  expCr;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 26;
  localparam vec_t VEC [NVEC] = '{
    // R2 R3: SNaN cause raises VX and FX
    '{4'd0, 32'h0100_0000, 1'b1, 1'b1, 5'h04, 5'd0, 3'd0, 1'b0, 32'hA106_4000, 1'b0, 1'b0, 4'h0, 4'd3},
    // R4: clear FX
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd31, 3'd0, 1'b0, 32'h2106_4000, 1'b0, 1'b0, 4'h0, 4'd4},
    // R3: same cause again does not set FX
    '{4'd0, 32'h0100_0000, 1'b0, 1'b0, 5'h02, 5'd0, 3'd0, 1'b0, 32'h2100_2000, 1'b0, 1'b0, 4'h0, 4'd3},
    // R3: new cause while VX already 1 sets FX
    '{4'd0, 32'h0080_0000, 1'b0, 1'b0, 5'h02, 5'd0, 3'd0, 1'b0, 32'hA180_2000, 1'b0, 1'b0, 4'h0, 4'd3},
    // R4
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd31, 3'd0, 1'b0, 32'h2180_2000, 1'b0, 1'b0, 4'h0, 4'd4},
    // R5: enabling VE makes FEX
    '{4'd6, 32'h0, 1'b0, 1'b0, 5'h0, 5'd7, 3'd0, 1'b0, 32'h6180_2080, 1'b0, 1'b0, 4'h0, 4'd5},
    // R11: enabled 0/0 suppresses
    '{4'd0, 32'h0020_0000, 1'b1, 1'b0, 5'h11, 5'd0, 3'd0, 1'b0, 32'hE1A5_1080, 1'b1, 1'b0, 4'h0, 4'd11},
    // R6: move-type leaves word alone
    '{4'd2, 32'h0200_0000, 1'b1, 1'b1, 5'h1F, 5'd0, 3'd0, 1'b0, 32'hE1A5_1080, 1'b0, 1'b0, 4'h0, 4'd6},
    // R7: round-to-integer drops inexact, clears FR FI
    '{4'd3, 32'h0200_0000, 1'b1, 1'b1, 5'h04, 5'd0, 3'd0, 1'b0, 32'hE1A0_4080, 1'b0, 1'b0, 4'h0, 4'd7},
    // R8: special-case clears FR FI
    '{4'd1, 32'h0, 1'b1, 1'b1, 5'h05, 5'd0, 3'd0, 1'b0, 32'hE1A0_5080, 1'b0, 1'b0, 4'h0, 4'd8},
    // R2: arithmetic raises XX, loads FR FI
    '{4'd0, 32'h0200_0000, 1'b1, 1'b1, 5'h08, 5'd0, 3'd0, 1'b0, 32'hE3A6_8080, 1'b0, 1'b0, 4'h0, 4'd2},
    // R9: convert-from-integer replaces FR FI
    '{4'd5, 32'h0, 1'b0, 1'b0, 5'h08, 5'd0, 3'd0, 1'b0, 32'hE3A0_8080, 1'b0, 1'b0, 4'h0, 4'd9},
    // R10: convert-to-integer zeroes class, enabled cause suppresses
    '{4'd4, 32'h0000_0100, 1'b1, 1'b0, 5'h04, 5'd0, 3'd0, 1'b0, 32'hE3A4_0180, 1'b1, 1'b0, 4'h0, 4'd10},
    // R4: reserved bit 11 ignores set
    '{4'd6, 32'h0, 1'b0, 1'b0, 5'h0, 5'd11, 3'd0, 1'b0, 32'hE3A4_0180, 1'b0, 1'b0, 4'h0, 4'd4},
    // R4
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd31, 3'd0, 1'b0, 32'h63A4_0180, 1'b0, 1'b0, 4'h0, 4'd4},
    // R4: set-bit of a cause sets FX
    '{4'd6, 32'h0, 1'b0, 1'b0, 5'h0, 5'd10, 3'd0, 1'b0, 32'hE3A4_0580, 1'b0, 1'b0, 4'h0, 4'd4},
    // R4: VX not clearable
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd29, 3'd0, 1'b0, 32'hE3A4_0580, 1'b0, 1'b0, 4'h0, 4'd4},
    // R4: FEX not clearable
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd30, 3'd0, 1'b0, 32'hE3A4_0580, 1'b0, 1'b0, 4'h0, 4'd4},
    // R4: enable ZE
    '{4'd6, 32'h0, 1'b0, 1'b0, 5'h0, 5'd4, 3'd0, 1'b0, 32'hE3A4_0590, 1'b0, 1'b0, 4'h0, 4'd4},
    // R11: enabled zero-divide suppresses
    '{4'd0, 32'h0400_0000, 1'b0, 1'b0, 5'h02, 5'd0, 3'd0, 1'b0, 32'hE7A0_2590, 1'b1, 1'b0, 4'h0, 4'd11},
    // R5: FEX held by ZX&ZE after VE cleared
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd7, 3'd0, 1'b0, 32'hE7A0_2510, 1'b0, 1'b0, 4'h0, 4'd5},
    // R5: FEX drops with ZE cleared
    '{4'd7, 32'h0, 1'b0, 1'b0, 5'h0, 5'd4, 3'd0, 1'b0, 32'hA7A0_2500, 1'b0, 1'b0, 4'h0, 4'd5},
    // R12: field 5 = bits 11:8, reserved bit reads 0
    '{4'd8, 32'h0, 1'b0, 1'b0, 5'h0, 5'd0, 3'd5, 1'b0, 32'hA7A0_2500, 1'b0, 1'b1, 4'h5, 4'd12},
    // R12: field 0 = bits 31:28
    '{4'd8, 32'h0, 1'b0, 1'b0, 5'h0, 5'd0, 3'd0, 1'b0, 32'hA7A0_2500, 1'b0, 1'b1, 4'hA, 4'd12},
    // R13: plain read with record
    '{4'd9, 32'h0, 1'b0, 1'b0, 5'h0, 5'd0, 3'd0, 1'b1, 32'hA7A0_2500, 1'b0, 1'b1, 4'hA, 4'd13},
    // R13: read variant ignores record
    '{4'd10, 32'h0, 1'b0, 1'b0, 5'h0, 5'd0, 3'd0, 1'b1, 32'hA7A0_2500, 1'b0, 1'b0, 4'h0, 4'd13}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 status", statusReg, 32'h0);
    check("R1 suppress", {31'b0, suppressWrite}, 32'h0);
    check("R1 crWe", {31'b0, crWe}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      instDone    = 1'b1;
      opClass     = VEC[i].cls;
      newExc      = VEC[i].exc;
      frIn        = VEC[i].fr;
      fiIn        = VEC[i].fi;
      resultClass = VEC[i].rc;
      bitIdx      = VEC[i].idx;
      fieldIdx    = VEC[i].fld;
      recordBit   = VEC[i].rec;
      @(negedge clk);
      instDone = 1'b0;
      check($sformatf("R%0d status vec%0d", VEC[i].req, i), statusReg, VEC[i].expStat);
      check($sformatf("R%0d suppress vec%0d", VEC[i].req, i), {31'b0, suppressWrite}, {31'b0, VEC[i].expSup});
      check($sformatf("R%0d crWe vec%0d", VEC[i].req, i), {31'b0, crWe}, {31'b0, VEC[i].expCrWe});
      if (VEC[i].expCrWe)
        check($sformatf("R%0d crField vec%0d", VEC[i].req, i), {28'b0, crField}, {28'b0, VEC[i].expCr});
    end

    // R6: no completion, arithmetic inputs present
    opClass = 4'd0; newExc = 32'h1000_0000; frIn = 1'b1; fiIn = 1'b1; resultClass = 5'h1F;
    instDone = 1'b0;
    @(negedge clk);
    check("R6 idle status", statusReg, 32'hA7A0_2500);

    // R11: no enabled exception, no suppress
    instDone = 1'b1; opClass = 4'd0; newExc = 32'h1000_0000; frIn = 1'b0; fiIn = 1'b0; resultClass = 5'h02;
    @(negedge clk);
    instDone = 1'b0;
    check("R11 no suppress", {31'b0, suppressWrite}, 32'h0);
    // R3: OX rising sets FX (already set, stays), OX stored
    check("R3 ox status", statusReg, 32'hB7A0_2500);

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rereset status", statusReg, 32'h0);
    check("R1 rereset crWe", {31'b0, crWe}, 32'h0);

    finishRun();
  end

endmodule